// File: doc/BRIEF.md
# Multiprocessor Address Recognition Filter

This block sits after a UART receiver working with 9-bit frames and decides whether an address frame is meant for this node. Each frame arrives already assembled. Bit 8 set marks an address frame and bit 8 clear marks a data frame. The node keeps two 8-bit registers, a slave address and a mask, and compares each address byte against them in two ways.

The first comparison is the node's own address. Every mask bit at 1 forces the matching frame bit to equal the slave address bit, and every mask bit at 0 leaves that frame bit free. The second comparison is a broadcast pattern, the bitwise OR of the two registers. Every 1 in that pattern must be a 1 in the frame, and its 0 bits are free. A hit on either comparison selects the node, so it then takes data frames. A miss deselects it. Both registers reset to zero, so the node answers every address.

Top module: `mp_addr_filter`

## Requirements
- R1: After a synchronous reset, `match_pulse`, `selected` and `frm_accept` are 0 and both registers hold 0.
- R2: With `mp_en` high, an address frame (`frm_data[8]`=1) hits the own address when every bit set in the mask has `frm_data[7:0]` equal to the slave address in that bit. Bits cleared in the mask are ignored.
- R3: An address frame also hits when every bit set in (slave address OR mask) is also set in `frm_data[7:0]`.
- R4: A hit shows one cycle after the frame as `match_pulse`=1 and `frm_accept`=1, and `selected` becomes 1. The pulse stays high only if a further frame hits.
- R5: With `mp_en` high, an address frame that misses both comparisons clears `selected`, with `match_pulse`=0 and `frm_accept`=0 in the next cycle.
- R6: With `mp_en` high, a data frame (`frm_data[8]`=0) gives `frm_accept` in the next cycle equal to `selected` in the frame's cycle. A data frame leaves `selected` unchanged.
- R7: With `mp_en` low, every valid frame is accepted in the next cycle. No pulse is raised, and only `sel_clear` changes `selected`.
- R8: `sel_clear` drops `selected` in the next cycle. If an address frame is evaluated in the same cycle, the frame's result wins.
- R9: `reg_we` with `reg_sel`=0 writes the slave address and with `reg_sel`=1 writes the mask. A frame in the same cycle as the write still uses the old values. The new value applies from the next frame.
- R10: While both registers are zero, every address frame hits.
- R11: `filter_armed` is high exactly when `mp_en` is high and the mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the slave address, 1 selects the mask |
| reg_wdata | input | 8 | Register write data |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| frm_valid | input | 1 | A received frame is present |
| frm_data | input | 9 | Frame, bit 8 is the address marker |
| sel_clear | input | 1 | Software clear of the selected state |
| match_pulse | output | 1 | One-cycle address hit indication |
| selected | output | 1 | Sticky node-selected state |
| frm_accept | output | 1 | Previous-cycle frame is passed to the node |
| filter_armed | output | 1 | Filtering is active with a nonzero mask |

## Verification
Two events can land in the same cycle: a software clear of `selected` and the evaluation of an address frame. The bench issues `sel_clear` together with a hitting address frame and expects `selected` to stay 1 with a pulse. It issues the clear together with a missing address frame and expects `selected` to be 0. It also issues the clear together with a data frame and expects the frame to be judged on the old state. A second overlap, a register write in the same cycle as a frame, is judged by checking that the frame uses the old register values.

// File: rtl/mpaf_pkg.sv
package mpaf_pkg;
    localparam int ADDR_W_DEF = 8;

    typedef enum logic {
        SEL_SLAVE = 1'b0,
        SEL_MASK  = 1'b1
    } regsel_e;

    typedef struct packed {
        logic own;
        logic bcast;
    } hit_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_BYPASS,
        EV_ADDR,
        EV_DATA
    } frame_ev_e;

    function automatic logic any_hit(hit_t h);
        return h.own | h.bcast;
    endfunction
endpackage

// File: rtl/mpaf_regs.sv
module mpaf_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] slave_q,
    output logic [W-1:0] mask_q
);
    import mpaf_pkg::*;

    regsel_e target;
    assign target = regsel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            slave_q <= '0;
            mask_q  <= '0;
        end else if (we) begin
            if (target == SEL_MASK) mask_q <= wdata;
            else                    slave_q <= wdata;
        end
    end
endmodule

// File: rtl/mpaf_match.sv
module mpaf_match #(
    parameter int W = 8
) (
    input  logic [W-1:0]  slave_q,
    input  logic [W-1:0]  mask_q,
    input  logic [W-1:0]  body,
    output mpaf_pkg::hit_t hit
);
    logic [W-1:0] own_ok;
    logic [W-1:0] bc_ok;
    logic [W-1:0] bc_pat;

    assign bc_pat = slave_q | mask_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign own_ok[i] = ~mask_q[i] | (body[i] == slave_q[i]);
        assign bc_ok[i]  = ~bc_pat[i] | body[i];
    end

    assign hit.own   = &own_ok;
    assign hit.bcast = &bc_ok;
endmodule

// File: rtl/mpaf_select.sv
module mpaf_select (
    input  logic           clk,
    input  logic           rst,
    input  logic           mp_en,
    input  logic           valid,
    input  logic           is_addr,
    input  mpaf_pkg::hit_t hit,
    input  logic           clr,
    output logic           pulse_q,
    output logic           sel_q,
    output logic           acc_q
);
    import mpaf_pkg::*;

    frame_ev_e ev;

    always_comb begin
        if (!valid)       ev = EV_NONE;
        else if (!mp_en)  ev = EV_BYPASS;
        else if (is_addr) ev = EV_ADDR;
        else              ev = EV_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            sel_q   <= 1'b0;
            acc_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            acc_q   <= 1'b0;
            unique case (ev)
                EV_ADDR: begin
                    pulse_q <= any_hit(hit);
                    sel_q   <= any_hit(hit);
                    acc_q   <= any_hit(hit);
                end
                EV_DATA: begin
                    acc_q <= sel_q;
                    if (clr) sel_q <= 1'b0;
                end
                EV_BYPASS: begin
                    acc_q <= 1'b1;
                    if (clr) sel_q <= 1'b0;
                end
                default: begin
                    if (clr) sel_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter #(
    parameter int W = mpaf_pkg::ADDR_W_DEF,
    localparam int FW = W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [W-1:0]  reg_wdata,
    input  logic          mp_en,
    input  logic          frm_valid,
    input  logic [FW-1:0] frm_data,
    input  logic          sel_clear,
    output logic          match_pulse,
    output logic          selected,
    output logic          frm_accept,
    output logic          filter_armed
);
    logic [W-1:0]   slave_q;
    logic [W-1:0]   mask_q;
    mpaf_pkg::hit_t hit;

    mpaf_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .slave_q (slave_q),
        .mask_q  (mask_q)
    );

    mpaf_match #(.W(W)) u_match (
        .slave_q (slave_q),
        .mask_q  (mask_q),
        .body    (frm_data[W-1:0]),
        .hit     (hit)
    );

    mpaf_select u_sel (
        .clk     (clk),
        .rst     (rst),
        .mp_en   (mp_en),
        .valid   (frm_valid),
        .is_addr (frm_data[W]),
        .hit     (hit),
        .clr     (sel_clear),
        .pulse_q (match_pulse),
        .sel_q   (selected),
        .acc_q   (frm_accept)
    );

    assign filter_armed = mp_en & (|mask_q);
endmodule

// File: rtl/mpaf_checker.sv
module mpaf_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         mp_en,
    input logic         frm_valid,
    input logic [W:0]   frm_data,
    input logic         sel_clear,
    input logic         match_pulse,
    input logic         selected,
    input logic         frm_accept
);
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    a_r4_pulse_needs_addr: assert property (@(posedge clk) disable iff (rst)
        live && match_pulse |-> $past(frm_valid && frm_data[W] && mp_en));

    a_r4_pulse_selects: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> selected && frm_accept);

    a_r5_miss_deselects: assert property (@(posedge clk) disable iff (rst)
        live && $past(frm_valid && frm_data[W] && mp_en) && !match_pulse |-> !selected && !frm_accept);

    a_r6_data_follows_sel: assert property (@(posedge clk) disable iff (rst)
        live && $past(frm_valid && !frm_data[W] && mp_en) |-> frm_accept == $past(selected));

    a_r7_bypass_accepts: assert property (@(posedge clk) disable iff (rst)
        live && $past(frm_valid && !mp_en) |-> frm_accept && !match_pulse);

    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        live && $past(sel_clear && !(frm_valid && frm_data[W] && mp_en)) |-> !selected);
endmodule

bind mp_addr_filter mpaf_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mp_en       (mp_en),
    .frm_valid   (frm_valid),
    .frm_data    (frm_data),
    .sel_clear   (sel_clear),
    .match_pulse (match_pulse),
    .selected    (selected),
    .frm_accept  (frm_accept)
);

// File: tb/tb_mp_addr_filter.sv
`timescale 1ns/1ps
module tb_mp_addr_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       mp_en = 1'b0;
    logic       frm_valid = 1'b0;
    logic [8:0] frm_data = '0;
    logic       sel_clear = 1'b0;
    logic       match_pulse, selected, frm_accept, filter_armed;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit started = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [7:0] m_slave = '0, m_mask = '0;
    bit m_sel = 0, m_pulse = 0, m_acc = 0;

    always #2.5 clk = ~clk;

    mp_addr_filter dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mp_en(mp_en), .frm_valid(frm_valid),
        .frm_data(frm_data), .sel_clear(sel_clear), .match_pulse(match_pulse),
        .selected(selected), .frm_accept(frm_accept), .filter_armed(filter_armed)
    );

    function automatic bit ref_hit(logic [7:0] b, logic [7:0] s, logic [7:0] m);
        bit own = 1, bc = 1;
        for (int i = 0; i < 8; i++) begin
            if (m[i] && (b[i] != s[i])) own = 0;
            if ((s[i] | m[i]) && !b[i]) bc = 0;
        end
        return own || bc;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_slave = '0; m_mask = '0; m_sel = 0; m_pulse = 0; m_acc = 0;
        end else begin
            bit h;
            h = ref_hit(frm_data[7:0], m_slave, m_mask);
            m_pulse = 0; m_acc = 0;
            if (frm_valid && !mp_en) begin
                m_acc = 1;
                if (sel_clear) m_sel = 0;
            end else if (frm_valid && frm_data[8]) begin
                m_pulse = h; m_acc = h; m_sel = h;
            end else begin
                if (frm_valid) m_acc = m_sel;
                if (sel_clear) m_sel = 0;
            end
            if (reg_we) begin
                if (reg_sel) m_mask = reg_wdata;
                else         m_slave = reg_wdata;
            end
        end
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("match_pulse", match_pulse, m_pulse);
            chk("selected", selected, m_sel);
            chk("frm_accept", frm_accept, m_acc);
            chk("filter_armed", filter_armed, mp_en && (m_mask != 0));
        end
    end

    task automatic idle();
        @(negedge clk); #1;
        reg_we = 0; frm_valid = 0; sel_clear = 0;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk); #1;
        reg_we = 1; reg_sel = sel; reg_wdata = d; frm_valid = 0; sel_clear = 0;
        idle();
    endtask

    task automatic frame(bit is_addr, logic [7:0] b, bit clr = 0);
        @(negedge clk); #1;
        reg_we = 0; frm_valid = 1; frm_data = {is_addr, b}; sel_clear = clr;
    endtask

    task automatic report();
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst = 0;
        idle(); idle();

        cur_req = "R10"; mp_en = 1;
        frame(1, 8'h00); frame(1, 8'h5A); frame(1, 8'hFF); idle();

        cur_req = "R2"; wr(0, 8'hC0); wr(1, 8'hF9);
        frame(1, 8'hC0); frame(1, 8'hC6); frame(1, 8'hC1); frame(1, 8'hC4);
        frame(1, 8'h40); frame(1, 8'hC2); idle();
        wr(0, 8'hE0); wr(1, 8'hFA);
        frame(1, 8'hE4); frame(1, 8'hE5); frame(1, 8'hE7); idle();

        cur_req = "R3"; wr(0, 8'hC0); wr(1, 8'hFC);
        frame(1, 8'hFC); frame(1, 8'hFF); frame(1, 8'h7C); idle();

        cur_req = "R4"; frame(1, 8'hC3); idle(); idle();
        cur_req = "R6"; frame(0, 8'h11); frame(0, 8'h22); idle();
        cur_req = "R5"; frame(1, 8'h83); idle();
        cur_req = "R6"; frame(0, 8'h33); idle();

        cur_req = "R7"; mp_en = 0;
        frame(1, 8'h00); frame(0, 8'h44); idle();
        mp_en = 1; frame(1, 8'hC0); mp_en = 0; frame(0, 8'h55, 1); idle();
        mp_en = 1;

        cur_req = "R8";
        frame(1, 8'hC1); idle(); sel_clear = 1; idle();
        frame(1, 8'hC2, 1); idle();
        frame(1, 8'h01, 1); idle();
        frame(1, 8'hC0); frame(0, 8'h66, 1); frame(0, 8'h77); idle();

        cur_req = "R9";
        @(negedge clk); #1;
        reg_we = 1; reg_sel = 0; reg_wdata = 8'h0F; frm_valid = 1; frm_data = {1'b1, 8'hC0};
        idle();
        frame(1, 8'hC0); frame(1, 8'h0C); idle();
        @(negedge clk); #1;
        reg_we = 1; reg_sel = 1; reg_wdata = 8'h00; frm_valid = 1; frm_data = {1'b1, 8'h30};
        idle();
        frame(1, 8'h30); idle();

        cur_req = "R11"; mp_en = 0; idle(); mp_en = 1; idle();
        wr(1, 8'h01); idle(); mp_en = 0; idle(); mp_en = 1; idle();

        cur_req = "R3";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            reg_we = (lfsr[3:0] == 4'h5);
            reg_sel = lfsr[4];
            reg_wdata = lfsr[15:8] | 8'h80;
            frm_valid = lfsr[5] | lfsr[6];
            frm_data = {lfsr[7], lfsr[15:8]};
            sel_clear = (lfsr[11:9] == 3'b101);
            mp_en = (lfsr[14:12] != 3'b000);
        end
        idle(); idle();

        cur_req = "R1"; rst = 1; idle(); rst = 0; idle(); idle();
        report();
    end
endmodule